// File: doc/BRIEF.md
# Serial Command Front End for a Byte-Wide Nonvolatile Memory

This block is the slave side of a four-wire serial link (chip select, clock, data in, data out) plus a pause input. It sits in front of a byte-organised nonvolatile store. All four serial inputs pass through synchronisers into one fast system clock, and their edges are detected in that domain. Bits are taken on rising serial-clock edges and presented on falling ones. Both idle-low (mode 0) and idle-high (mode 3) clock polarity are accepted. Every exchange carries an 8-bit command first, then for array commands a 16-bit address, then data bytes, each sent most significant bit first.

The block decodes the command and streams status or array bytes back. It hands array-byte, commit, status-write and write-enable requests to a separate write engine and protection unit, which may hold the block in a busy state. The store is a synchronous register file inside the block. The write engine fills it through a dedicated write port.

The serial data output is given as a value plus an output-enable. `so_oe` low stands for high impedance.

Top module: `spi_ee_front`

## Requirements
- R1: A command byte is valid only when its upper four bits are zero. Bit 3 is ignored, and bits 2..0 select the command: 110 set write-enable (one `wel_set` pulse), 100 clear write-enable (one `wel_clr` pulse), 101 status read, 001 status write, 011 array read, 010 array write.
- R2: After an invalid command byte, no later bit in that selection causes a request, and `so_oe` stays low until chip select falls again.
- R3: While chip select is high, serial clock and data activity change nothing and `so_oe` is low.
- R4: Pulling the pause input low while the serial clock is low freezes the bit position and drives `so_oe` low. Clock edges during the pause are ignored. Releasing the pause while the clock is low resumes at the same bit.
- R5: An array read uses only the low log2(DEPTH) bits of its 16-bit address. It streams bytes from consecutive addresses and wraps from DEPTH-1 to 0.
- R6: A status read returns `status_in` on every following byte, for as long as clocks continue.
- R7: While `busy` is high at the end of a command byte, only the status read is obeyed. Any other command is treated as invalid (R2).
- R8: Each complete data byte of an array write gives one `pg_load` pulse with its address and data. After each byte the low log2(PAGE) address bits count up and wrap, while the upper bits stay fixed.
- R9: On the rise of chip select, `pg_go` pulses after an array write, and `sr_wr` pulses with the received byte after a status write. In both cases this happens only if at least one data byte arrived and the select rose exactly on a byte boundary.
- R10: Mode 3 transfers (clock idle high at select) give the same results as mode 0.
- R11: After reset, `so_oe` is low and no request output is active.
- R12: At most one of `wel_set`, `wel_clr`, `sr_wr`, `pg_load`, `pg_go` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause input, active low |
| so | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for `so`; low means high impedance |
| busy | input | 1 | Write engine busy |
| status_in | input | 8 | Status byte supplied by the protection unit |
| wel_set | output | 1 | Pulse: set write-enable latch |
| wel_clr | output | 1 | Pulse: clear write-enable latch |
| sr_wr | output | 1 | Pulse: commit status byte |
| sr_data | output | 8 | Status byte to commit |
| pg_load | output | 1 | Pulse: one array write byte received |
| pg_addr | output | AW | Address for `pg_load` |
| pg_data | output | 8 | Data for `pg_load` |
| pg_go | output | 1 | Pulse: start array programming |
| mem_we | input | 1 | Write engine store write enable |
| mem_waddr | input | AW | Write engine store address |
| mem_wdata | input | 8 | Write engine store data |

## Verification
Some rules can be checked on every cycle, and assertions cover them. The lockout holds until the next select falls, and a locked selection never drives the output. State does not move while deselected or paused. The busy gate at command decode sends every command except status read to lockout. Requests are mutually exclusive, and a programming commit happens only on a byte boundary of an array write. Other properties need whole exchanges, so only the bench scenarios show them: correct data ordering, address wrap and masking, page wrap, repeating status, resuming after a pause, and mode 3 equivalence.

// File: rtl/spi_ee_pkg.sv
// Shared types for the serial memory front end.
// Assumes: command codes live in bits 2..0 of the first byte.
package spi_ee_pkg;
    typedef enum logic [2:0] {
        PH_OPC, PH_ADDR, PH_RDAT, PH_WDAT, PH_STAT, PH_WSR, PH_DONE, PH_LOCK
    } phase_t;

    localparam logic [2:0] OP_WEN_SET = 3'b110;
    localparam logic [2:0] OP_WEN_CLR = 3'b100;
    localparam logic [2:0] OP_STAT_RD = 3'b101;
    localparam logic [2:0] OP_STAT_WR = 3'b001;
    localparam logic [2:0] OP_ARR_RD  = 3'b011;
    localparam logic [2:0] OP_ARR_WR  = 3'b010;
endpackage

// File: rtl/spi_ee_sync.sv
// Multi-stage level synchroniser for asynchronous pins.
// Assumes: each bit is independent; edges are found by the consumer.
module spi_ee_sync #(
    parameter int           W       = 4,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl
);
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [W-1:0] q;
        if (g == 0) begin : g_in
            // first capture stage
            always_ff @(posedge clk) begin
                if (!rst_n) q <= RST_VAL;
                else        q <= din;
            end
        end else begin : g_chain
            // further metastability stages
            always_ff @(posedge clk) begin
                if (!rst_n) q <= RST_VAL;
                else        q <= g_stage[g-1].q;
            end
        end
    end

    assign lvl = g_stage[STAGES-1].q;
endmodule

// File: rtl/spi_ee_regfile.sv
// Synchronous byte store: one write port, one registered read port.
// Assumes: read data is used at least one cycle after the read strobe.
module spi_ee_regfile #(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    // store write
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // registered read
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/spi_ee_ctrl.sv
// Serial command sequencer: shifts bits, decodes commands, streams
// output bytes and raises requests for the write engine.
// Assumes: synchronised inputs; serial half period >= 4 system clocks.
module spi_ee_ctrl
    import spi_ee_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int PAGE  = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = $clog2(PAGE),
    localparam int HIW  = AW - 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_lvl,
    input  logic          sck_lvl,
    input  logic          si_lvl,
    input  logic          hold_lvl,
    input  logic          busy,
    input  logic [7:0]    status_in,
    input  logic [7:0]    rd_data,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          so,
    output logic          so_oe,
    output logic          wel_set,
    output logic          wel_clr,
    output logic          sr_wr,
    output logic [7:0]    sr_data,
    output logic          pg_load,
    output logic [AW-1:0] pg_addr,
    output logic [7:0]    pg_data,
    output logic          pg_go
);
    phase_t          phase;
    logic [2:0]      cnt;
    logic [6:0]      shin;
    logic            cs_prev, sck_prev;
    logic            held, is_rd, addr_idx, wseen, sr_pend, out_on, so_q;
    logic [HIW-1:0]  ahi;
    logic [AW-1:0]   cur_addr;
    logic [7:0]      obuf;

    logic cs_fall, cs_rise, sck_rise, sck_fall, adv, byte_done, shout;
    logic [7:0] byte_in, out_src;

    assign cs_fall   = cs_prev & ~cs_lvl;
    assign cs_rise   = ~cs_prev & cs_lvl;
    assign sck_rise  = sck_lvl & ~sck_prev;
    assign sck_fall  = ~sck_lvl & sck_prev;
    assign byte_in   = {shin, si_lvl};
    assign adv       = !cs_lvl && !cs_fall && !held && sck_rise && phase != PH_LOCK;
    assign byte_done = adv && cnt == 3'd7;
    assign shout     = !cs_lvl && !cs_fall && !held && sck_fall &&
                       (phase == PH_STAT || phase == PH_RDAT);
    assign out_src   = (phase == PH_STAT) ? status_in : rd_data;
    assign so        = so_q;
    assign so_oe     = out_on && !held && !cs_lvl;

    // edge history of select and clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_prev  <= 1'b1;
            sck_prev <= 1'b0;
        end else begin
            cs_prev  <= cs_lvl;
            sck_prev <= sck_lvl;
        end
    end

    // pause flag follows the pause pin only while the clock is low
    always_ff @(posedge clk) begin
        if (!rst_n)        held <= 1'b0;
        else if (cs_lvl)   held <= 1'b0;
        else if (!sck_lvl) held <= !hold_lvl;
    end

    // command sequencer, input shifter and request generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_DONE;
            cnt      <= '0;
            shin     <= '0;
            is_rd    <= 1'b0;
            addr_idx <= 1'b0;
            wseen    <= 1'b0;
            sr_pend  <= 1'b0;
            ahi      <= '0;
            cur_addr <= '0;
            rd_en    <= 1'b0;
            rd_addr  <= '0;
            wel_set  <= 1'b0;
            wel_clr  <= 1'b0;
            sr_wr    <= 1'b0;
            sr_data  <= '0;
            pg_load  <= 1'b0;
            pg_addr  <= '0;
            pg_data  <= '0;
            pg_go    <= 1'b0;
        end else begin
            rd_en   <= 1'b0;
            wel_set <= 1'b0;
            wel_clr <= 1'b0;
            sr_wr   <= 1'b0;
            pg_load <= 1'b0;
            pg_go   <= 1'b0;
            if (cs_fall) begin
                phase    <= PH_OPC;
                cnt      <= '0;
                addr_idx <= 1'b0;
                wseen    <= 1'b0;
                sr_pend  <= 1'b0;
            end else if (cs_rise) begin
                if (phase == PH_WDAT && cnt == 3'd0 && wseen) pg_go <= 1'b1;
                if (sr_pend && cnt == 3'd0)                    sr_wr <= 1'b1;
                sr_pend <= 1'b0;
                wseen   <= 1'b0;
            end else if (adv) begin
                shin <= byte_in[6:0];
                cnt  <= cnt + 3'd1;
                if (byte_done) begin
                    unique case (phase)
                        PH_OPC: begin
                            if (byte_in[7:4] != 4'd0)
                                phase <= PH_LOCK;
                            else if (busy && byte_in[2:0] != OP_STAT_RD)
                                phase <= PH_LOCK;
                            else begin
                                unique case (byte_in[2:0])
                                    OP_WEN_SET: begin wel_set <= 1'b1; phase <= PH_DONE; end
                                    OP_WEN_CLR: begin wel_clr <= 1'b1; phase <= PH_DONE; end
                                    OP_STAT_RD: phase <= PH_STAT;
                                    OP_STAT_WR: phase <= PH_WSR;
                                    OP_ARR_RD:  begin is_rd <= 1'b1; phase <= PH_ADDR; end
                                    OP_ARR_WR:  begin is_rd <= 1'b0; phase <= PH_ADDR; end
                                    default:    phase <= PH_LOCK;
                                endcase
                            end
                        end
                        PH_ADDR: begin
                            if (!addr_idx) begin
                                ahi      <= byte_in[HIW-1:0];
                                addr_idx <= 1'b1;
                            end else begin
                                cur_addr <= {ahi, byte_in};
                                if (is_rd) begin
                                    rd_en   <= 1'b1;
                                    rd_addr <= {ahi, byte_in};
                                    phase   <= PH_RDAT;
                                end else begin
                                    phase <= PH_WDAT;
                                end
                            end
                        end
                        PH_RDAT: begin
                            cur_addr <= cur_addr + AW'(1);
                            rd_addr  <= cur_addr + AW'(1);
                            rd_en    <= 1'b1;
                        end
                        PH_WDAT: begin
                            pg_load  <= 1'b1;
                            pg_addr  <= cur_addr;
                            pg_data  <= byte_in;
                            wseen    <= 1'b1;
                            cur_addr <= {cur_addr[AW-1:PW], cur_addr[PW-1:0] + PW'(1)};
                        end
                        PH_WSR: begin
                            sr_data <= byte_in;
                            sr_pend <= 1'b1;
                            phase   <= PH_DONE;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // output shifter: new bit on each falling clock edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_on <= 1'b0;
            obuf   <= '0;
            so_q   <= 1'b0;
        end else if (cs_fall || cs_rise) begin
            out_on <= 1'b0;
        end else if (shout) begin
            out_on <= 1'b1;
            if (cnt == 3'd0) begin
                obuf <= out_src;
                so_q <= out_src[7];
            end else begin
                so_q <= obuf[~cnt];
            end
        end
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LOCK && !cs_fall) |=> phase == PH_LOCK); // R2
    AST_LOCK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LOCK) |-> !so_oe); // R2
    AST_DESEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        cs_lvl |=> $stable(cnt) && $stable(shin)); // R3
    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> $stable(cnt) && $stable(so_q)); // R4
    AST_BUSY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && phase == PH_OPC && busy) |=> (phase == PH_STAT || phase == PH_LOCK)); // R7
    AST_GO_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        pg_go |-> (cnt == 3'd0 && phase == PH_WDAT)); // R9
    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wel_set, wel_clr, sr_wr, pg_load, pg_go})); // R12
endmodule

// File: rtl/spi_ee_front.sv
// Top of the serial memory front end: synchronisers, sequencer, store.
// Assumes: DEPTH and PAGE are powers of two, DEPTH > 256.
module spi_ee_front #(
    parameter int DEPTH = 1024,
    parameter int PAGE  = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sck,
    input  logic          si,
    input  logic          hold_n,
    output logic          so,
    output logic          so_oe,
    input  logic          busy,
    input  logic [7:0]    status_in,
    output logic          wel_set,
    output logic          wel_clr,
    output logic          sr_wr,
    output logic [7:0]    sr_data,
    output logic          pg_load,
    output logic [AW-1:0] pg_addr,
    output logic [7:0]    pg_data,
    output logic          pg_go,
    input  logic          mem_we,
    input  logic [AW-1:0] mem_waddr,
    input  logic [7:0]    mem_wdata
);
    logic [3:0]    pins_s;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;

    spi_ee_sync #(.W(4), .STAGES(2), .RST_VAL(4'b1001)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({hold_n, si, sck, cs_n}),
        .lvl   (pins_s)
    );

    spi_ee_regfile #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .re    (rd_en),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    spi_ee_ctrl #(.DEPTH(DEPTH), .PAGE(PAGE)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_lvl    (pins_s[0]),
        .sck_lvl   (pins_s[1]),
        .si_lvl    (pins_s[2]),
        .hold_lvl  (pins_s[3]),
        .busy      (busy),
        .status_in (status_in),
        .rd_data   (rd_data),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .so        (so),
        .so_oe     (so_oe),
        .wel_set   (wel_set),
        .wel_clr   (wel_clr),
        .sr_wr     (sr_wr),
        .sr_data   (sr_data),
        .pg_load   (pg_load),
        .pg_addr   (pg_addr),
        .pg_data   (pg_data),
        .pg_go     (pg_go)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!so_oe && !wel_set && !wel_clr && !sr_wr && !pg_load && !pg_go)); // R11
endmodule

// File: tb/spi_ee_front_bench.sv
// Bench: behavioural serial master plus an event model. Every request
// pulse is compared on each clock with a queue of expected events.
module spi_ee_front_bench;
    localparam int DEPTH = 1024;
    localparam int PAGE  = 32;
    localparam int AW    = $clog2(DEPTH);
    localparam int HP    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, busy = 1'b0;
    logic [7:0] status_in = 8'h00;
    logic mem_we = 1'b0;
    logic [AW-1:0] mem_waddr = '0;
    logic [7:0] mem_wdata = '0;
    logic so, so_oe, wel_set, wel_clr, sr_wr, pg_load, pg_go;
    logic [7:0] sr_data, pg_data;
    logic [AW-1:0] pg_addr;

    int total = 0;
    int bad = 0;
    bit m3 = 1'b0;
    logic [7:0] mdl [DEPTH];
    logic [31:0] exp_q [$];

    always #2.5 clk = ~clk;

    spi_ee_front #(.DEPTH(DEPTH), .PAGE(PAGE)) u_spi_ee_front (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
        .so(so), .so_oe(so_oe), .busy(busy), .status_in(status_in),
        .wel_set(wel_set), .wel_clr(wel_clr), .sr_wr(sr_wr), .sr_data(sr_data),
        .pg_load(pg_load), .pg_addr(pg_addr), .pg_data(pg_data), .pg_go(pg_go),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ev(input int kind, input int addr, input int data);
        return {4'(kind), 4'd0, 16'(addr), 8'(data)};
    endfunction

    task automatic note_ev(input logic [31:0] got);
        logic [31:0] want;
        if (exp_q.size() == 0) begin
            chk(1'b0, "R12 unexpected request", got, 32'h0);
        end else begin
            want = exp_q.pop_front();
            chk(got == want, "R8/R9/R1 request", got, want);
        end
    endtask

    // per-clock comparison of request pulses with the expected queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (wel_set) note_ev(ev(1, 0, 0));
            if (wel_clr) note_ev(ev(2, 0, 0));
            if (sr_wr)   note_ev(ev(3, 0, sr_data));
            if (pg_load) note_ev(ev(4, pg_addr, pg_data));
            if (pg_go)   note_ev(ev(5, 0, 0));
        end
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xbits(input logic [7:0] d, input int hi, input int lo,
                         input bit eo, input logic [7:0] evb, input string req);
        for (int i = hi; i >= lo; i--) begin
            if (m3) sck = 1'b0;
            si = d[i];
            wt(HP);
            chk(so_oe === eo, req, 32'(so_oe), 32'(eo));
            if (eo) chk(so === evb[i], req, 32'(so), 32'(evb[i]));
            sck = 1'b1;
            wt(HP);
            if (!m3) sck = 1'b0;
        end
    endtask

    task automatic sel_on();
        sck = m3;
        wt(HP);
        cs_n = 1'b0;
        wt(HP);
    endtask

    task automatic sel_off(input string req);
        wt(HP);
        cs_n = 1'b1;
        wt(2 * HP);
        chk(exp_q.size() == 0, req, 32'(exp_q.size()), 32'd0);
        chk(so_oe === 1'b0, req, 32'(so_oe), 32'd0);
    endtask

    task automatic do_read(input logic [15:0] a, input int n, input string req);
        logic [AW-1:0] p;
        p = a[AW-1:0];
        sel_on();
        xbits(8'h0B, 7, 0, 0, 8'h00, req);
        xbits(a[15:8], 7, 0, 0, 8'h00, req);
        xbits(a[7:0], 7, 0, 0, 8'h00, req);
        for (int k = 0; k < n; k++) begin
            xbits(8'hFF, 7, 0, 1, mdl[p], req);
            p = p + AW'(1);
        end
        sel_off(req);
    endtask

    initial begin
        wt(4);
        chk(so_oe === 1'b0, "R11 oe in reset", 32'(so_oe), 32'd0);
        rst_n = 1'b1;
        wt(2);
        chk(so_oe === 1'b0, "R11 oe after reset", 32'(so_oe), 32'd0);

        // preload the store through the write-engine port
        for (int i = 0; i < DEPTH; i++) begin
            mem_we = 1'b1;
            mem_waddr = AW'(i);
            mem_wdata = 8'((i * 37 + 5) ^ (i >> 3));
            mdl[i] = 8'((i * 37 + 5) ^ (i >> 3));
            wt(1);
        end
        mem_we = 1'b0;
        wt(4);

        // R1: set/clear latch, with bit 3 both clear and set
        exp_q.push_back(ev(1, 0, 0));
        sel_on(); xbits(8'h06, 7, 0, 0, 8'h00, "R1 set"); sel_off("R1 set");
        exp_q.push_back(ev(1, 0, 0));
        sel_on(); xbits(8'h0E, 7, 0, 0, 8'h00, "R1 set bit3"); sel_off("R1 set bit3");
        exp_q.push_back(ev(2, 0, 0));
        sel_on(); xbits(8'h04, 7, 0, 0, 8'h00, "R1 clr"); sel_off("R1 clr");

        // R6: status read repeats
        status_in = 8'hA5;
        sel_on();
        xbits(8'h05, 7, 0, 0, 8'h00, "R6 status");
        for (int k = 0; k < 3; k++) xbits(8'hFF, 7, 0, 1, 8'hA5, "R6 status repeat");
        sel_off("R6 status");

        // R5: read with don't-care upper address bits and wrap to zero
        do_read(16'hF3FE, 4, "R5 read wrap");
        do_read(16'h0123, 2, "R5 read plain");

        // R8 + R9: page write with low-bit wrap, then commit
        exp_q.push_back(ev(4, 16'h13E, 8'h11));
        exp_q.push_back(ev(4, 16'h13F, 8'h22));
        exp_q.push_back(ev(4, 16'h120, 8'h33));
        exp_q.push_back(ev(4, 16'h121, 8'h44));
        exp_q.push_back(ev(5, 0, 0));
        sel_on();
        xbits(8'h02, 7, 0, 0, 8'h00, "R8 write");
        xbits(8'h01, 7, 0, 0, 8'h00, "R8 write");
        xbits(8'h3E, 7, 0, 0, 8'h00, "R8 write");
        xbits(8'h11, 7, 0, 0, 8'h00, "R8 write");
        xbits(8'h22, 7, 0, 0, 8'h00, "R8 write");
        xbits(8'h33, 7, 0, 0, 8'h00, "R8 write");
        xbits(8'h44, 7, 0, 0, 8'h00, "R8 write");
        sel_off("R9 commit");

        // R9: select rises mid-byte, so no commit
        exp_q.push_back(ev(4, 16'h005, 8'h55));
        sel_on();
        xbits(8'h02, 7, 0, 0, 8'h00, "R9 abort");
        xbits(8'h00, 7, 0, 0, 8'h00, "R9 abort");
        xbits(8'h05, 7, 0, 0, 8'h00, "R9 abort");
        xbits(8'h55, 7, 0, 0, 8'h00, "R9 abort");
        xbits(8'h66, 7, 5, 0, 8'h00, "R9 abort");
        sel_off("R9 no commit mid-byte");

        // R9: status write commits on boundary, not mid-byte
        exp_q.push_back(ev(3, 0, 8'h8C));
        sel_on();
        xbits(8'h01, 7, 0, 0, 8'h00, "R9 status write");
        xbits(8'h8C, 7, 0, 0, 8'h00, "R9 status write");
        sel_off("R9 status commit");
        sel_on();
        xbits(8'h01, 7, 0, 0, 8'h00, "R9 status abort");
        xbits(8'h8C, 7, 0, 0, 8'h00, "R9 status abort");
        xbits(8'hC0, 7, 6, 0, 8'h00, "R9 status abort");
        sel_off("R9 status no commit");

        // R2: invalid commands lock out the rest of the selection
        sel_on();
        xbits(8'h07, 7, 0, 0, 8'h00, "R2 invalid 111");
        xbits(8'h06, 7, 0, 0, 8'h00, "R2 locked");
        xbits(8'h05, 7, 0, 0, 8'h00, "R2 locked");
        sel_off("R2 invalid 111");
        sel_on();
        xbits(8'h46, 7, 0, 0, 8'h00, "R2 invalid upper");
        xbits(8'h06, 7, 0, 0, 8'h00, "R2 locked");
        sel_off("R2 invalid upper");
        status_in = 8'h5A;
        sel_on();
        xbits(8'h05, 7, 0, 0, 8'h00, "R2 recovered");
        xbits(8'hFF, 7, 0, 1, 8'h5A, "R2 recovered");
        sel_off("R2 recovered");

        // R7: busy ignores all but status read
        busy = 1'b1;
        sel_on(); xbits(8'h06, 7, 0, 0, 8'h00, "R7 busy set"); sel_off("R7 busy set ignored");
        sel_on();
        xbits(8'h03, 7, 0, 0, 8'h00, "R7 busy read");
        xbits(8'h00, 7, 0, 0, 8'h00, "R7 busy read");
        xbits(8'h10, 7, 0, 0, 8'h00, "R7 busy read");
        xbits(8'hFF, 7, 0, 0, 8'h00, "R7 busy read silent");
        sel_off("R7 busy read");
        status_in = 8'hFF;
        sel_on();
        xbits(8'h05, 7, 0, 0, 8'h00, "R7 busy status");
        xbits(8'h00, 7, 0, 1, 8'hFF, "R7 busy status");
        sel_off("R7 busy status");
        busy = 1'b0;

        // R4: pause mid-byte during a read, clock toggles, resume
        sel_on();
        xbits(8'h03, 7, 0, 0, 8'h00, "R4 pause");
        xbits(8'h00, 7, 0, 0, 8'h00, "R4 pause");
        xbits(8'h10, 7, 0, 0, 8'h00, "R4 pause");
        xbits(8'hFF, 7, 0, 1, mdl[16], "R4 pause");
        xbits(8'hFF, 7, 5, 1, mdl[17], "R4 pause");
        wt(HP);
        hold_n = 1'b0;
        wt(HP);
        for (int k = 0; k < 3; k++) begin
            si = 1'b1; sck = 1'b1; wt(HP);
            sck = 1'b0; wt(HP);
            chk(so_oe === 1'b0, "R4 oe off while paused", 32'(so_oe), 32'd0);
        end
        hold_n = 1'b1;
        wt(HP);
        xbits(8'hFF, 4, 0, 1, mdl[17], "R4 resume");
        xbits(8'hFF, 7, 0, 1, mdl[18], "R4 next byte");
        sel_off("R4 pause");

        // R3: activity while deselected has no effect
        sel_on();
        xbits(8'h00, 7, 4, 0, 8'h00, "R3 partial");
        wt(HP); cs_n = 1'b1; wt(2 * HP);
        for (int k = 0; k < 12; k++) begin
            si = k[0]; sck = 1'b1; wt(HP);
            chk(so_oe === 1'b0, "R3 oe deselected", 32'(so_oe), 32'd0);
            sck = 1'b0; wt(HP);
        end
        chk(exp_q.size() == 0, "R3 no request", 32'(exp_q.size()), 32'd0);
        exp_q.push_back(ev(2, 0, 0));
        sel_on(); xbits(8'h04, 7, 0, 0, 8'h00, "R3 after"); sel_off("R3 after");

        // R10: mode 3 status read and array read
        m3 = 1'b1;
        status_in = 8'h3C;
        sel_on();
        xbits(8'h05, 7, 0, 0, 8'h00, "R10 status");
        xbits(8'h00, 7, 0, 1, 8'h3C, "R10 status");
        xbits(8'h00, 7, 0, 1, 8'h3C, "R10 status");
        sel_off("R10 status");
        do_read(16'h0200, 2, "R10 read");
        m3 = 1'b0;
        sck = 1'b0;
        wt(HP);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule